// File: doc/BRIEF.md
# Packet-Count Status and Interrupt Unit

This block keeps the transmit and receive status of an Ethernet MAC's DMA engines and turns it into a single interrupt line. Each DMA engine sends it one-cycle event pulses. The transmit side reports packet sent and underrun. The receive side reports packet received and overflow. For each direction the block counts packets in an 8-bit counter and keeps a packet flag plus one error flag.

Software reaches the block through a small synchronous register port. That port has a word address, a write enable, 32-bit write data and a registered read path. Writing a one to the packet bit of a status register acknowledges a single packet. The write takes one off that direction's counter, and the flag falls only once the counter has reached zero. Error flags are cleared by writing a one to them.

An 8-bit mask selects which of the eight status bits raise the interrupt. The low nibble of the transmit status forms interrupt bits 3:0 and the low nibble of the receive status forms bits 7:4. The masked value can be read back at its own address. The interrupt output is driven from a register.

Top module: `pkt_status_irq`

## Requirements
- R1: After reset the transmit status, receive status, mask and interrupt value all read zero, and `irqOut` is low.
- R2: A packet event (`txSentEv` or `rxRcvdEv`) adds one to that direction's counter and sets its packet flag. The counter is in status bits 23:16 and the flag is in bit 0. The other direction is not affected.
- R3: `txUnderEv` sets transmit status bit 1. `rxOverEv` sets receive status bit 2. Neither event changes a counter.
- R4: Writing a status word with bit 0 set takes one off that counter. The packet flag clears only when the result is zero. A counter already at zero stays at zero, and its flag clears.
- R5: Writing a one to the error bit of a status register clears that flag. This is bit 1 at the transmit address and bit 2 at the receive address. Zero bits and all other bit positions in the written word leave the register unchanged.
- R6: If a packet event and a packet acknowledge reach the same direction in the same cycle, the counter keeps its value and the packet flag is set.
- R7: If an error event and a write that clears the same error flag arrive in the same cycle, the flag ends up set.
- R8: Word address 2 holds the mask in bits 7:0. Word address 3 reads mask AND {rx_status[3:0], tx_status[3:0]} and ignores writes.
- R9: `irqOut` is high exactly one cycle after the masked interrupt value becomes non-zero, and low one cycle after it becomes zero.
- R10: `regRdata` shows the register selected by `regAddr` one clock after the address is presented. Address 0 is transmit status, 1 is receive status, 2 is the mask and 3 is the interrupt value. Any other address reads zero.
- R11: The counter wraps from 255 to 0 on a packet event, and the packet flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Registered read data |
| txSentEv | input | 1 | Transmit packet-sent pulse |
| txUnderEv | input | 1 | Transmit underrun pulse |
| rxRcvdEv | input | 1 | Receive packet-received pulse |
| rxOverEv | input | 1 | Receive overflow pulse |
| irqOut | output | 1 | Level interrupt, registered |

## Verification
The bench focuses on the packet-acknowledge path:
- It counts down through several packets. A design that cleared the flag on the first acknowledge would lose the pending packets.
- It acknowledges a counter already at zero. A design without the floor would wrap to 255.
- It presents an event and an acknowledge in the same cycle. A design that let either side win would gain or lose one packet.

It also writes each error bit at the wrong address, where a loose decode would clear a flag. It writes to the interrupt address, where a careless decode would overwrite the mask. It steps the mask and checks `irqOut` one cycle at a time to catch an interrupt that is a cycle early or a cycle late. It wraps the counter through 256 packets to show that the flag survives a zero count.

// File: rtl/pkt_stat_pkg.sv
package pkt_stat_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int CNT_W      = 8;
  localparam int CNT_LSB    = 16;
  localparam int NIB_W      = 4;
  localparam int TX_ERR_BIT = 1;
  localparam int RX_ERR_BIT = 2;
  localparam int TX_ADDR    = 0;
  localparam int RX_ADDR    = 1;
  localparam int MASK_ADDR  = 2;
  localparam int IRQ_ADDR   = 3;

  typedef enum logic [2:0] {
    SEL_TX, SEL_RX, SEL_MASK, SEL_IRQ, SEL_NONE
  } regSelT;

  // Strobes from control to datapath; index 0 = transmit, 1 = receive
  typedef struct packed {
    logic [1:0] ackPkt;
    logic [1:0] clrErr;
    logic       maskWr;
    regSelT     rdSel;
  } strobeT;
endpackage

// File: rtl/pkt_stat_ctrl.sv
module pkt_stat_ctrl
  import pkt_stat_pkg::*;
#(
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W,
  parameter int TX_A   = TX_ADDR,
  parameter int RX_A   = RX_ADDR,
  parameter int MASK_A = MASK_ADDR,
  parameter int IRQ_A  = IRQ_ADDR,
  parameter int TX_EB  = TX_ERR_BIT,
  parameter int RX_EB  = RX_ERR_BIT
) (
  input  logic [AW-1:0] addr,
  input  logic          wrEn,
  input  logic [DW-1:0] wdata,
  output strobeT        stb
);
  logic unusedWdata;
  assign unusedWdata = ^wdata;

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    if (addr == AW'(TX_A)) begin
      stb.rdSel     = SEL_TX;
      stb.ackPkt[0] = wrEn & wdata[0];
      stb.clrErr[0] = wrEn & wdata[TX_EB];
    end else if (addr == AW'(RX_A)) begin
      stb.rdSel     = SEL_RX;
      stb.ackPkt[1] = wrEn & wdata[0];
      stb.clrErr[1] = wrEn & wdata[RX_EB];
    end else if (addr == AW'(MASK_A)) begin
      stb.rdSel  = SEL_MASK;
      stb.maskWr = wrEn;
    end else if (addr == AW'(IRQ_A)) begin
      stb.rdSel = SEL_IRQ;
    end
  end
endmodule

// File: rtl/pkt_stat_dir.sv
module pkt_stat_dir
  import pkt_stat_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int CW   = CNT_W,
  parameter int CLSB = CNT_LSB,
  parameter int NW   = NIB_W,
  parameter int EBIT = TX_ERR_BIT
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          evPkt,
  input  logic          evErr,
  input  logic          ack,
  input  logic          clrErr,
  output logic [DW-1:0] statWord,
  output logic [NW-1:0] statNib
);
  localparam logic [CW-1:0] CNT_ZERO = '0;
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt;
  logic          pktFlag;
  logic          errFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= CNT_ZERO;
      pktFlag <= 1'b0;
    end else if (evPkt && ack) begin
      pktFlag <= 1'b1;
    end else if (evPkt) begin
      cnt     <= cnt + CNT_ONE;
      pktFlag <= 1'b1;
    end else if (ack) begin
      if (cnt != CNT_ZERO) cnt <= cnt - CNT_ONE;
      if (cnt <= CNT_ONE) pktFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       errFlag <= 1'b0;
    else if (evErr)  errFlag <= 1'b1;
    else if (clrErr) errFlag <= 1'b0;
  end

  always_comb begin
    statWord             = '0;
    statWord[CLSB +: CW] = cnt;
    statWord[0]          = pktFlag;
    statWord[EBIT]       = errFlag;
  end
  assign statNib = statWord[NW-1:0];

  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evPkt && !ack) |=> (cnt == $past(cnt) + CNT_ONE) && pktFlag);
  p_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !evPkt && cnt > CNT_ONE) |=> (cnt == $past(cnt) - CNT_ONE) && $stable(pktFlag));
  p_floor_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !evPkt && cnt <= CNT_ONE) |=> (cnt == CNT_ZERO) && !pktFlag);
  p_collide_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ack && evPkt) |=> $stable(cnt) && pktFlag);
  p_err_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    evErr |=> errFlag);
  p_err_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (clrErr && !evErr) |=> !errFlag);
endmodule

// File: rtl/pkt_stat_dp.sv
module pkt_stat_dp
  import pkt_stat_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int CW    = CNT_W,
  parameter int CLSB  = CNT_LSB,
  parameter int NW    = NIB_W,
  parameter int TX_EB = TX_ERR_BIT,
  parameter int RX_EB = RX_ERR_BIT
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    evPkt,
  input  logic [1:0]    evErr,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int DIRS   = 2;
  localparam int MASK_W = NW * DIRS;

  logic [DW-1:0]     statWord [DIRS];
  logic [NW-1:0]     statNib  [DIRS];
  logic [MASK_W-1:0] maskReg;
  logic [MASK_W-1:0] isrVal;

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    localparam int EB = (d == 0) ? TX_EB : RX_EB;
    pkt_stat_dir #(
      .DW(DW), .CW(CW), .CLSB(CLSB), .NW(NW), .EBIT(EB)
    ) i_dir (
      .clk(clk), .rstN(rstN),
      .evPkt(evPkt[d]), .evErr(evErr[d]),
      .ack(stb.ackPkt[d]), .clrErr(stb.clrErr[d]),
      .statWord(statWord[d]), .statNib(statNib[d])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskReg <= '0;
    else if (stb.maskWr) maskReg <= wdata[MASK_W-1:0];
  end

  assign isrVal = maskReg & {statNib[1], statNib[0]};

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |isrVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else begin
      case (stb.rdSel)
        SEL_TX:   rdata <= statWord[0];
        SEL_RX:   rdata <= statWord[1];
        SEL_MASK: rdata <= DW'(maskReg);
        SEL_IRQ:  rdata <= DW'(isrVal);
        default:  rdata <= '0;
      endcase
    end
  end

  p_mask_wr_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.maskWr |=> maskReg == $past(wdata[MASK_W-1:0]));
  p_irq_ro_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == SEL_IRQ) |=> $stable(maskReg));
  p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((maskReg & {statNib[1], statNib[0]}) == '0) |=> !irq);
endmodule

// File: rtl/pkt_status_irq.sv
module pkt_status_irq
  import pkt_stat_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          txSentEv,
  input  logic          txUnderEv,
  input  logic          rxRcvdEv,
  input  logic          rxOverEv,
  output logic          irqOut
);
  strobeT stb;

  pkt_stat_ctrl #(.AW(AW), .DW(DW)) i_ctrl (
    .addr(regAddr), .wrEn(regWrEn), .wdata(regWdata), .stb(stb)
  );

  pkt_stat_dp #(.DW(DW)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(regWdata),
    .evPkt({rxRcvdEv, txSentEv}), .evErr({rxOverEv, txUnderEv}),
    .rdata(regRdata), .irq(irqOut)
  );
endmodule

// File: tb/test_pkt_status_irq.sv
`timescale 1ns/1ps
module test_pkt_status_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        txSentEv = 1'b0, txUnderEv = 1'b0, rxRcvdEv = 1'b0, rxOverEv = 1'b0;
  logic        irqOut;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pkt_status_irq i_pkt_status_irq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWdata(regWdata), .regRdata(regRdata), .txSentEv(txSentEv),
    .txUnderEv(txUnderEv), .rxRcvdEv(rxRcvdEv), .rxOverEv(rxOverEv),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0;
    {txSentEv, txUnderEv, rxRcvdEv, rxOverEv} = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b0;
    @(posedge clk); #1;
    v = regRdata;
  endtask

  // sel: 0 tx sent, 1 underrun, 2 rx received, 3 overflow
  task automatic pulse(input int sel, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (sel)
        0: txSentEv = 1'b1;
        1: txUnderEv = 1'b1;
        2: rxRcvdEv = 1'b1;
        default: rxOverEv = 1'b1;
      endcase
      @(negedge clk);
      {txSentEv, txUnderEv, rxRcvdEv, rxOverEv} = '0;
    end
  endtask

  task automatic tReset();
    logic [31:0] v;
    doReset();
    for (int a = 0; a < 4; a++) begin
      rd(4'(a), v); chk("R1 reset value", v, 32'h0);
    end
    chk("R1 irq low", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic tCount();
    logic [31:0] v;
    doReset();
    pulse(0, 3);
    rd(4'd0, v); chk("R2 tx count 3", v, 32'h0003_0001);
    rd(4'd1, v); chk("R2 rx untouched", v, 32'h0);
    pulse(2, 2);
    rd(4'd1, v); chk("R2 rx count 2", v, 32'h0002_0001);
  endtask

  task automatic tAck();
    logic [31:0] v;
    doReset();
    pulse(0, 3);
    wr(4'd0, 32'h1); rd(4'd0, v); chk("R4 dec to 2", v, 32'h0002_0001);
    wr(4'd0, 32'h0); rd(4'd0, v); chk("R5 zero write no effect", v, 32'h0002_0001);
    wr(4'd0, 32'h1); rd(4'd0, v); chk("R4 dec to 1", v, 32'h0001_0001);
    wr(4'd0, 32'h1); rd(4'd0, v); chk("R4 dec to 0 clears flag", v, 32'h0);
    wr(4'd0, 32'h1); rd(4'd0, v); chk("R4 floor at zero", v, 32'h0);
  endtask

  task automatic tErr();
    logic [31:0] v;
    doReset();
    pulse(1, 1); pulse(3, 1);
    rd(4'd0, v); chk("R3 underrun bit1", v, 32'h2);
    rd(4'd1, v); chk("R3 overflow bit2", v, 32'h4);
    wr(4'd0, 32'h4); rd(4'd0, v); chk("R5 wrong bit at tx ignored", v, 32'h2);
    wr(4'd1, 32'h2); rd(4'd1, v); chk("R5 wrong bit at rx ignored", v, 32'h4);
    wr(4'd0, 32'h2); rd(4'd0, v); chk("R5 underrun cleared", v, 32'h0);
    wr(4'd1, 32'h4); rd(4'd1, v); chk("R5 overflow cleared", v, 32'h0);
  endtask

  task automatic tCollide();
    logic [31:0] v;
    doReset();
    pulse(0, 2);
    @(negedge clk);
    regAddr = 4'd0; regWdata = 32'h1; regWrEn = 1'b1; txSentEv = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; txSentEv = 1'b0;
    rd(4'd0, v); chk("R6 event+ack holds count", v, 32'h0002_0001);
    pulse(3, 1);
    @(negedge clk);
    regAddr = 4'd1; regWdata = 32'h4; regWrEn = 1'b1; rxOverEv = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; rxOverEv = 1'b0;
    rd(4'd1, v); chk("R7 set beats clear", v, 32'h4);
  endtask

  task automatic tIrq();
    logic [31:0] v;
    doReset();
    pulse(2, 1);
    rd(4'd3, v); chk("R8 masked off reads 0", v, 32'h0);
    chk("R9 irq low when masked", {31'b0, irqOut}, 32'h0);
    // mask write lands on edge k, irq follows on edge k+1
    @(negedge clk);
    regAddr = 4'd2; regWdata = 32'h10; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    chk("R9 irq not yet high", {31'b0, irqOut}, 32'h0);
    @(posedge clk); #1;
    chk("R9 irq high one cycle later", {31'b0, irqOut}, 32'h1);
    rd(4'd2, v); chk("R8 mask readback", v, 32'h10);
    rd(4'd3, v); chk("R8 irq value rx bit", v, 32'h10);
    wr(4'd3, 32'hFF);
    rd(4'd3, v); chk("R8 irq write ignored", v, 32'h10);
    rd(4'd2, v); chk("R8 mask kept after irq write", v, 32'h10);
    wr(4'd1, 32'h1);
    @(posedge clk); #1;
    chk("R9 irq low after ack", {31'b0, irqOut}, 32'h0);
    wr(4'd2, 32'h02);
    pulse(1, 1);
    rd(4'd3, v); chk("R8 underrun in bit1", v, 32'h02);
    chk("R9 irq from underrun", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic tWrap();
    logic [31:0] v;
    doReset();
    pulse(0, 256);
    rd(4'd0, v); chk("R11 wrap keeps flag", v, 32'h0000_0001);
    wr(4'd0, 32'h1);
    rd(4'd0, v); chk("R4 ack at wrapped zero", v, 32'h0);
  endtask

  task automatic tAddr();
    logic [31:0] v;
    doReset();
    pulse(0, 1);
    rd(4'd5, v); chk("R10 unmapped reads 0", v, 32'h0);
    rd(4'd0, v); chk("R10 tx at address 0", v, 32'h0001_0001);
  endtask

  initial begin
    tReset();
    tCount();
    tAck();
    tErr();
    tCollide();
    tIrq();
    tWrap();
    tAddr();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule